// File: doc/BRIEF.md
# FPGA Configuration Mode Controller

This block sequences the configuration of an attached programmable device. Software programs a control register over a 32-bit word-addressed register bus to select data width and clock-to-data ratio, to enable the sequencer, and to assert the active-low configuration-request line to the target. A phase machine follows the target through reset, configuration, initialisation and user mode. It advances on the request line, on the returning done and status handshake pins, and on the completion of a burst of extra configuration clocks.

Configuration data enters through a separate write port. A word is passed on to the target only while the data-enable control bit is set. A word that arrives while the bit is clear is discarded, and a sticky error flag records the drop. A status word reports the current phase, the mode-select pins as sampled, and the drop flag. While the target's power-good input is low, the reported phase is zero.

Top module: `cfgmode_ctrl`

## Requirements
- R1: After synchronous reset, the control register reads 0, the reported phase is 0, `tgt_ncfg` is 1, `tgt_nce` is 0, `tgt_xclk` is 0 and `cfg_vld` is 0.
- R2: The control register sits at word 1. It keeps bit 0 (enable), bit 1 (chip-enable level), bit 2 (request pull), bits 7:6 (clock ratio), bit 8 (data enable) and bit 9 (width, 1 = 32-bit). All other bits read 0. `tgt_nce` follows bit 1.
- R3: `tgt_ncfg` is low exactly when both enable and request pull are set. With enable clear, setting the pull bit leaves `tgt_ncfg` high and leaves the phase unchanged.
- R4: The status word sits at word 0, with the phase in bits 2:0. The phase codes are 0 power-up, 1 reset, 2 configuration, 3 initialisation, 4 user and 5 fault. With power good, an effective pull moves the phase to 1. Releasing the pull moves the phase from 1 to 2.
- R5: In phase 2, the phase moves to 3 on the cycle the extra-clock burst finishes, provided `tgt_conf_done` and `tgt_nstatus` are both high at that time. On the following cycle the phase moves to 4.
- R6: In phase 2 with `tgt_conf_done` and `tgt_nstatus` both low, the phase moves to 5. It stays at 5 until a new pull.
- R7: While `tgt_pwr_good` is low, the phase reads 0 and the sequencer returns to power-up. Once power returns, it stays at 0 until a new pull.
- R8: Writing N to word 2 drives `tgt_xclk` high for exactly N cycles, starting the cycle after the write. Word 2 reads the remaining count. When the burst ends, word 3 bit 0 is set. Writing 1 to that bit clears it.
- R9: A data-port write with data enable set appears on `cfg_vld`/`cfg_dat` one cycle later. With data enable clear, the write is dropped (`cfg_vld` stays 0) and status bit 8 is set. Writing 1 to status bit 8 clears it.
- R10: Status bits 7:3 return `msel_pins` as registered one cycle earlier.
- R11: A data-port write in the same cycle as a control write is gated by the data-enable value held before that control write.
- R12: `reg_rdata` is registered. It presents the addressed word on the cycle after `reg_ren`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word index of the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| dat_wen | input | 1 | Configuration data write strobe |
| dat_wdata | input | DATA_W | Configuration data word |
| msel_pins | input | 5 | Mode-select pins |
| tgt_pwr_good | input | 1 | Target power good |
| tgt_conf_done | input | 1 | Target configuration done |
| tgt_nstatus | input | 1 | Target status, active low |
| tgt_ncfg | output | 1 | Configuration request, active low |
| tgt_nce | output | 1 | Target chip enable level |
| tgt_xclk | output | 1 | Extra configuration clock enable |
| cfg_vld | output | 1 | Forwarded data valid |
| cfg_dat | output | DATA_W | Forwarded data word |

## Verification
The data gate and the control register write can land on the same edge. The bench provokes this in both directions: it clears data enable in the very cycle a data word arrives, and it sets data enable in the very cycle another word arrives. The first word must be forwarded and the second must be dropped and flagged, which shows that the gate samples the control value held before the write. The bench also lets the extra-clock burst finish while the done and status pins are high, then checks that the phase reaches user mode after exactly the burst length plus one cycle.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;
  typedef enum logic [2:0] {
    PH_PWRUP  = 3'd0,
    PH_RESET  = 3'd1,
    PH_CONFIG = 3'd2,
    PH_INIT   = 3'd3,
    PH_USER   = 3'd4,
    PH_FAULT  = 3'd5
  } phase_t;

  localparam int MSEL_W = 5;
  localparam logic [31:0] CTRL_MASK = 32'h0000_03C7;

  localparam int CB_EN     = 0;
  localparam int CB_NCE    = 1;
  localparam int CB_PULL   = 2;
  localparam int CB_DATAEN = 8;

  localparam int SB_DROP = 8;

  localparam int W_STATUS = 0;
  localparam int W_CTRL   = 1;
  localparam int W_XCNT   = 2;
  localparam int W_XDONE  = 3;
endpackage

// File: rtl/cfgm_xclk.sv
module cfgm_xclk #(
  parameter int XCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [XCNT_W-1:0] load_val,
  input  logic              done_clr,
  output logic              xclk,
  output logic              done_q,
  output logic              done_evt,
  output logic [XCNT_W-1:0] cnt
);
  localparam logic [XCNT_W-1:0] ONE = XCNT_W'(1);

  assign done_evt = (cnt == ONE) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      xclk   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      xclk <= (cnt != '0);
      if (load)
        cnt <= load_val;
      else if (cnt != '0)
        cnt <= cnt - ONE;
      if (done_evt)
        done_q <= 1'b1;
      else if (done_clr)
        done_q <= 1'b0;
    end
  end

  a_r8_idle_no_clock: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |=> !xclk);
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done_q && !done_clr) |=> done_q);
endmodule

// File: rtl/cfgm_phase_fsm.sv
module cfgm_phase_fsm
  import cfgm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pwr_good,
  input  logic   pull_eff,
  input  logic   conf_done,
  input  logic   nstatus,
  input  logic   xdone_evt,
  output phase_t phase_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_PWRUP;
    end else if (!pwr_good) begin
      phase_q <= PH_PWRUP;
    end else if (pull_eff) begin
      phase_q <= PH_RESET;
    end else begin
      case (phase_q)
        PH_RESET:  phase_q <= PH_CONFIG;
        PH_CONFIG: begin
          if (conf_done && nstatus && xdone_evt)
            phase_q <= PH_INIT;
          else if (!conf_done && !nstatus)
            phase_q <= PH_FAULT;
        end
        PH_INIT:   phase_q <= PH_USER;
        default:   phase_q <= phase_q;
      endcase
    end
  end

  a_r7_power_loss: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (phase_q == PH_PWRUP));
  a_r4_pull_resets: assert property (@(posedge clk) disable iff (rst)
    (pwr_good && pull_eff) |=> (phase_q == PH_RESET));
  a_r5_init_to_user: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_INIT && pwr_good && !pull_eff) |=> (phase_q == PH_USER));
  a_r5_init_from_config: assert property (@(posedge clk) disable iff (rst)
    $changed(phase_q) && (phase_q == PH_INIT) |-> ($past(phase_q) == PH_CONFIG));
endmodule

// File: rtl/cfgm_data_gate.sv
module cfgm_data_gate #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dat_wen,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic              dataen,
  input  logic              err_clr,
  output logic              cfg_vld,
  output logic [DATA_W-1:0] cfg_dat,
  output logic              drop_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_vld  <= 1'b0;
      cfg_dat  <= '0;
      drop_err <= 1'b0;
    end else begin
      cfg_vld <= dat_wen && dataen;
      if (dat_wen && dataen)
        cfg_dat <= dat_wdata;
      if (dat_wen && !dataen)
        drop_err <= 1'b1;
      else if (err_clr)
        drop_err <= 1'b0;
    end
  end

  a_r9_drop_silent: assert property (@(posedge clk) disable iff (rst)
    (dat_wen && !dataen) |=> !cfg_vld);
  a_r9_drop_flagged: assert property (@(posedge clk) disable iff (rst)
    (dat_wen && !dataen) |=> drop_err);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (drop_err && !err_clr) |=> drop_err);
endmodule

// File: rtl/cfgm_regs.sv
module cfgm_regs
  import cfgm_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int XCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wen,
  input  logic              reg_ren,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [MSEL_W-1:0] msel_pins,
  input  logic              pwr_good,
  input  phase_t            phase,
  input  logic              drop_err,
  input  logic [XCNT_W-1:0] xcnt,
  input  logic              xdone,
  output logic [31:0]       ctrl_q,
  output logic              err_clr,
  output logic              xdone_clr,
  output logic              xcnt_load,
  output logic [XCNT_W-1:0] xcnt_val
);
  localparam int PAD_X = 32 - XCNT_W;
  localparam int PAD_S = 32 - 1 - MSEL_W - 3;

  logic [MSEL_W-1:0] msel_q;
  logic [2:0]        phase_rd;
  logic [31:0]       rd_mux;

  wire sel_status = (int'(reg_addr) == W_STATUS);
  wire sel_ctrl   = (int'(reg_addr) == W_CTRL);
  wire sel_xcnt   = (int'(reg_addr) == W_XCNT);
  wire sel_xdone  = (int'(reg_addr) == W_XDONE);

  assign err_clr   = reg_wen && sel_status && reg_wdata[SB_DROP];
  assign xdone_clr = reg_wen && sel_xdone && reg_wdata[0];
  assign xcnt_load = reg_wen && sel_xcnt;
  assign xcnt_val  = reg_wdata[XCNT_W-1:0];
  assign phase_rd  = pwr_good ? phase : PH_PWRUP;

  always_comb begin
    rd_mux = '0;
    if (sel_status)
      rd_mux = {{PAD_S{1'b0}}, drop_err, msel_q, phase_rd};
    else if (sel_ctrl)
      rd_mux = ctrl_q;
    else if (sel_xcnt)
      rd_mux = {{PAD_X{1'b0}}, xcnt};
    else if (sel_xdone)
      rd_mux = {31'd0, xdone};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      msel_q    <= '0;
      reg_rdata <= '0;
    end else begin
      msel_q <= msel_pins;
      if (reg_wen && sel_ctrl)
        ctrl_q <= reg_wdata & CTRL_MASK;
      if (reg_ren)
        reg_rdata <= rd_mux;
    end
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & ~CTRL_MASK) == 32'd0);
  a_r12_hold_without_read: assert property (@(posedge clk) disable iff (rst)
    !reg_ren |=> $stable(reg_rdata));
endmodule

// File: rtl/cfgmode_ctrl.sv
module cfgmode_ctrl
  import cfgm_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int XCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wen,
  input  logic              reg_ren,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dat_wen,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic [4:0]        msel_pins,
  input  logic              tgt_pwr_good,
  input  logic              tgt_conf_done,
  input  logic              tgt_nstatus,
  output logic              tgt_ncfg,
  output logic              tgt_nce,
  output logic              tgt_xclk,
  output logic              cfg_vld,
  output logic [DATA_W-1:0] cfg_dat
);
  logic [31:0]       ctrl_q;
  logic              err_clr, xdone_clr, xcnt_load;
  logic [XCNT_W-1:0] xcnt_val, xcnt;
  logic              xdone_q, xdone_evt, drop_err;
  logic              pull_eff;
  phase_t            phase_q;

  assign pull_eff = ctrl_q[CB_EN] && ctrl_q[CB_PULL];
  assign tgt_ncfg = !pull_eff;
  assign tgt_nce  = ctrl_q[CB_NCE];

  cfgm_regs #(.ADDR_W(ADDR_W), .XCNT_W(XCNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_ren(reg_ren),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msel_pins(msel_pins), .pwr_good(tgt_pwr_good), .phase(phase_q),
    .drop_err(drop_err), .xcnt(xcnt), .xdone(xdone_q), .ctrl_q(ctrl_q),
    .err_clr(err_clr), .xdone_clr(xdone_clr), .xcnt_load(xcnt_load),
    .xcnt_val(xcnt_val)
  );

  cfgm_xclk #(.XCNT_W(XCNT_W)) u_xclk (
    .clk(clk), .rst(rst), .load(xcnt_load), .load_val(xcnt_val),
    .done_clr(xdone_clr), .xclk(tgt_xclk), .done_q(xdone_q),
    .done_evt(xdone_evt), .cnt(xcnt)
  );

  cfgm_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .pwr_good(tgt_pwr_good), .pull_eff(pull_eff),
    .conf_done(tgt_conf_done), .nstatus(tgt_nstatus),
    .xdone_evt(xdone_evt), .phase_q(phase_q)
  );

  cfgm_data_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst(rst), .dat_wen(dat_wen), .dat_wdata(dat_wdata),
    .dataen(ctrl_q[CB_DATAEN]), .err_clr(err_clr), .cfg_vld(cfg_vld),
    .cfg_dat(cfg_dat), .drop_err(drop_err)
  );

  a_r3_no_pull_when_disabled: assert property (@(posedge clk) disable iff (rst)
    (tgt_pwr_good && !ctrl_q[CB_EN] && phase_q != PH_RESET) |=> (phase_q != PH_RESET));
endmodule

// File: tb/cfgmode_ctrl_tb.sv
module cfgmode_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wen = 1'b0, reg_ren = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dat_wen = 1'b0;
  logic [31:0] dat_wdata = '0;
  logic [4:0]  msel_pins = '0;
  logic        tgt_pwr_good = 1'b1, tgt_conf_done = 1'b0, tgt_nstatus = 1'b1;
  logic        tgt_ncfg, tgt_nce, tgt_xclk, cfg_vld;
  logic [31:0] cfg_dat;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cfgmode_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_ren(reg_ren),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dat_wen(dat_wen), .dat_wdata(dat_wdata), .msel_pins(msel_pins),
    .tgt_pwr_good(tgt_pwr_good), .tgt_conf_done(tgt_conf_done),
    .tgt_nstatus(tgt_nstatus), .tgt_ncfg(tgt_ncfg), .tgt_nce(tgt_nce),
    .tgt_xclk(tgt_xclk), .cfg_vld(cfg_vld), .cfg_dat(cfg_dat)
  );

  function automatic logic [31:0] exp_ctrl(logic [31:0] v);
    return v & 32'h0000_03C7;
  endfunction

  function automatic logic exp_ncfg(logic [31:0] v);
    return !(v[0] && v[2]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_ren = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_ren = 1'b0;
    d = reg_rdata;
  endtask

  task automatic dwrite(logic [31:0] d);
    @(negedge clk);
    dat_wen = 1'b1; dat_wdata = d;
    @(negedge clk);
    dat_wen = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int highs;
    bit first_high;
    bit err_m;
    void'($urandom(32'd2718));

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ncfg", tgt_ncfg, 1);
    chk("R1 nce", tgt_nce, 0);
    chk("R1 xclk", tgt_xclk, 0);
    chk("R1 vld", cfg_vld, 0);
    chk("R1 rdata", reg_rdata, 0);
    rd(2'd1, r); chk("R1 ctrl", r, 0);
    rd(2'd0, r); chk("R1 phase", r[2:0], 0);

    // R10 mode-select sampling
    msel_pins = 5'h13;
    rd(2'd0, r); chk("R10 msel", r[7:3], 5'h13);
    chk("R12 read data on next cycle", r[2:0], 0);

    // R4 pull to reset, release to configuration
    wr(2'd1, 32'h5);
    chk("R3 ncfg low with en and pull", tgt_ncfg, 0);
    rd(2'd0, r); chk("R4 phase reset", r[2:0], 1);
    wr(2'd1, 32'h1);
    rd(2'd0, r); chk("R4 phase config", r[2:0], 2);

    // R5 and R8: success handshake, then extra clock burst
    tgt_conf_done = 1'b1; tgt_nstatus = 1'b1;
    rd(2'd0, r); chk("R5 holds config before burst", r[2:0], 2);
    wr(2'd2, 32'd4);
    highs = 0; first_high = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 0) first_high = tgt_xclk;
      if (tgt_xclk) highs++;
    end
    chk("R8 burst starts next cycle", 32'(first_high), 1);
    chk("R8 burst length", highs, 4);
    rd(2'd0, r); chk("R5 phase user", r[2:0], 4);
    rd(2'd2, r); chk("R8 count drained", r, 0);
    rd(2'd3, r); chk("R8 done set", r, 1);
    wr(2'd3, 32'h1);
    rd(2'd3, r); chk("R8 done cleared", r, 0);

    // R3 pull ignored without enable
    wr(2'd1, 32'h4);
    chk("R3 ncfg stays high", tgt_ncfg, 1);
    rd(2'd0, r); chk("R3 phase unchanged", r[2:0], 4);

    // R6 failure path
    wr(2'd1, 32'h5);
    tgt_conf_done = 1'b0; tgt_nstatus = 1'b0;
    wr(2'd1, 32'h1);
    repeat (2) @(negedge clk);
    rd(2'd0, r); chk("R6 phase fault", r[2:0], 5);
    tgt_nstatus = 1'b1;
    rd(2'd0, r); chk("R6 fault held", r[2:0], 5);

    // R7 power loss
    tgt_pwr_good = 1'b0;
    rd(2'd0, r); chk("R7 phase zero without power", r[2:0], 0);
    tgt_pwr_good = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd0, r); chk("R7 stays power-up", r[2:0], 0);

    // R11 same-cycle control write and data write
    wr(2'd0, 32'h100);
    wr(2'd1, 32'h100);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0;
    dat_wen = 1'b1; dat_wdata = 32'hA5A5_0001;
    @(negedge clk);
    reg_wen = 1'b0; dat_wen = 1'b0;
    chk("R11 old enable forwards", cfg_vld, 1);
    chk("R11 forwarded word", cfg_dat, 32'hA5A5_0001);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h100;
    dat_wen = 1'b1; dat_wdata = 32'h5A5A_0002;
    @(negedge clk);
    reg_wen = 1'b0; dat_wen = 1'b0;
    chk("R11 old disable drops", cfg_vld, 0);
    rd(2'd0, r); chk("R11 drop flagged", r[8], 1);
    wr(2'd0, 32'h100);
    rd(2'd0, r); chk("R9 drop flag cleared", r[8], 0);

    // R2, R3, R9 random mix
    err_m = 0;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] v, d;
      v = $urandom; d = $urandom;
      wr(2'd1, v);
      rd(2'd1, r); chk("R2 ctrl readback", r, exp_ctrl(v));
      chk("R2 nce", tgt_nce, v[1]);
      chk("R3 ncfg", tgt_ncfg, exp_ncfg(v));
      dwrite(d);
      chk("R9 valid", cfg_vld, v[8]);
      if (v[8]) chk("R9 data", cfg_dat, d);
      else err_m = 1;
      rd(2'd0, r); chk("R9 drop flag", r[8], err_m);
      if ($urandom % 3 == 0) begin
        wr(2'd0, 32'h100);
        err_m = 0;
      end
    end

    finish_run();
  end
endmodule